// File: doc/BRIEF.md
# Protected Flash Command Engine

This block is the command front end of an on-chip flash controller, including a small register-based model of the flash array. Software loads a target byte address, a data word and a command code into registers. It then writes the commit value to the operation-control register. The engine goes busy for a fixed number of cycles and then applies the command to the array. The supported commands are word programming, page erase and mass erase. A separate read port returns array words one cycle after each access.

The block also guards the array against read-out. An option-byte area sits above main flash. The word at 0x1FF0_0010 holds a protection bit in bit 0, and protection is active when that bit is 0. The engine samples the bit once after each system reset and keeps that value until the next reset. While protection is active, permissions depend on who issues the request (a debug/in-circuit-programming port or the user application) and on the region the request targets. Mass erase is always accepted, and it is the only way to remove protection. The array survives a system reset and is only set to its erased state by a separate power-on reset.

Top module: `pflash_ctrl`

## Requirements
- R1: After system reset the mode field reads 0x6 and the error flag reads 0. Protection is taken from bit 0 of the word at 0x1FF0_0010, where 0 means active, and is sampled once just after reset. Programming that bit changes nothing until the next system reset. Register STATUS (select 4) bit 1 shows the latched protection state.
- R2: Writing 0xA to bits [3:0] of OPCTL (select 3) while idle commits the pending command. From the cycle after the commit edge, the mode field (OPCTL read) shows 0xA for exactly 8 cycles and then 0xE.
- R3: While busy, writes to TARGET (select 0), WDATA (select 1) and CMD (select 2) are ignored.
- R4: Command 0x4 programs the target word to old AND data. Erased words read 0xFFFF_FFFF.
- R5: Command 0x8 erases the page holding the target address. Main flash is split into pages of 4 words starting at byte address 0. The option area (8 words at 0x1FF0_0000) is erased as one page.
- R6: Command 0xA erases all main and option words. It is accepted from either requester in every protection state.
- R7: A read through the read port returns the word one cycle after the access. With protection active, a read while dbg_req is high returns 0. A user read, or any read while unprotected, returns the stored word.
- R8: With protection active, program and erase commands committed with dbg_req high are rejected and leave the array unchanged.
- R9: With protection active, user program and page erase commands aimed at page 0 (bytes 0x00–0x0F) or at the option area are rejected. All other user program and page erase commands are accepted.
- R10: A rejected operation still ends with mode 0xE and sets a sticky error flag in STATUS bit 0. Writing 1 to that bit clears the flag.
- R11: For program and erase, the requester is taken from dbg_req in the commit cycle. Changing dbg_req during the busy period has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on reset, active low; erases the array model |
| rst_n | input | 1 | System reset, active low; resets registers and re-samples protection |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 TARGET, 1 WDATA, 2 CMD, 3 OPCTL, 4 STATUS |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| dbg_req | input | 1 | High when the access comes from the debug/in-circuit-programming port |
| fl_rd | input | 1 | Array read strobe |
| fl_addr | input | 32 | Array read byte address |
| fl_rdata | output | 32 | Array read data, valid the cycle after fl_rd |

## Verification
Each result has a fixed due cycle. Register reads are combinational, and array read data appears one cycle after the access. The mode field shows 0xA from the first through the eighth cycle after the commit edge. The array change and the error flag are due in the ninth cycle, when mode becomes 0xE. The bench drives inputs on falling edges and counts falling edges from the commit. It checks the mode field in the first and eighth busy cycles, then checks mode, error flag and array contents exactly in the ninth. Array reads are compared on the falling edge that follows the access edge.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam logic [3:0] CMD_PROG   = 4'h4;
  localparam logic [3:0] CMD_PERASE = 4'h8;
  localparam logic [3:0] CMD_MERASE = 4'hA;

  localparam logic [3:0] MODE_BUSY = 4'hA;
  localparam logic [3:0] MODE_DONE = 4'hE;
  localparam logic [3:0] MODE_IDLE = 4'h6;
  localparam logic [3:0] GO_CODE   = 4'hA;

  localparam logic [2:0] SEL_TGT   = 3'd0;
  localparam logic [2:0] SEL_WDATA = 3'd1;
  localparam logic [2:0] SEL_CMD   = 3'd2;
  localparam logic [2:0] SEL_OPCTL = 3'd3;
  localparam logic [2:0] SEL_STAT  = 3'd4;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    logic        allow;
  } op_req_t;
endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [2:0]  sel_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        rej_i,
  input  logic        prot_i,
  input  logic [3:0]  mode_i,
  output logic [31:0] rdata_o,
  output logic [31:0] tgt_o,
  output logic [31:0] wd_o,
  output logic [3:0]  cmd_o,
  output logic        go_o
);
  logic [31:0] tgt_q, tgt_d;
  logic [31:0] wd_q, wd_d;
  logic [3:0]  cmd_q, cmd_d;
  logic        perr_q, perr_d;
  logic        open_wr;

  assign open_wr = wr_i && !busy_i;
  assign go_o    = open_wr && (sel_i == SEL_OPCTL) && (wdata_i[3:0] == GO_CODE);

  always_comb begin
    tgt_d  = tgt_q;
    wd_d   = wd_q;
    cmd_d  = cmd_q;
    perr_d = perr_q;
    if (open_wr && sel_i == SEL_TGT)   tgt_d = wdata_i;
    if (open_wr && sel_i == SEL_WDATA) wd_d  = wdata_i;
    if (open_wr && sel_i == SEL_CMD)   cmd_d = wdata_i[3:0];
    if (wr_i && sel_i == SEL_STAT && wdata_i[0]) perr_d = 1'b0;
    if (rej_i) perr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      wd_q   <= '0;
      cmd_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      wd_q   <= wd_d;
      cmd_q  <= cmd_d;
      perr_q <= perr_d;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_TGT:   rdata_o = tgt_q;
      SEL_WDATA: rdata_o = wd_q;
      SEL_CMD:   rdata_o = {28'd0, cmd_q};
      SEL_OPCTL: rdata_o = {28'd0, mode_i};
      SEL_STAT:  rdata_o = {30'd0, prot_i, perr_q};
      default:   rdata_o = '0;
    endcase
  end

  assign tgt_o = tgt_q;
  assign wd_o  = wd_q;
  assign cmd_o = cmd_q;

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(tgt_q) && $stable(wd_q) && $stable(cmd_q)));
  assert_perr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rej_i |=> perr_q);
endmodule

// File: rtl/pfc_guard.sv
module pfc_guard
  import pfc_pkg::*;
#(
  parameter int          WPP       = 4,
  parameter int          OPT_WORDS = 8,
  parameter logic [31:0] OPT_BASE  = 32'h1FF0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prot_bit_i,
  input  logic [3:0]  cmd_i,
  input  logic [31:0] addr_i,
  input  logic        dbg_i,
  output logic        prot_o,
  output logic        loading_o,
  output logic        allow_o
);
  localparam logic [31:0] PAGE0_END = 32'(WPP * 4);
  localparam logic [31:0] OPT_END   = OPT_BASE + 32'(OPT_WORDS * 4);

  logic prot_q, prot_d;
  logic load_q, load_d;
  logic locked_region;

  always_comb begin
    prot_d = prot_q;
    load_d = load_q;
    if (load_q) begin
      prot_d = ~prot_bit_i;
      load_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b1;
      load_q <= 1'b1;
    end else begin
      prot_q <= prot_d;
      load_q <= load_d;
    end
  end

  assign locked_region = (addr_i < PAGE0_END) || (addr_i >= OPT_BASE && addr_i < OPT_END);

  always_comb begin
    allow_o = 1'b1;
    if (prot_q && (cmd_i == CMD_PROG || cmd_i == CMD_PERASE))
      allow_o = !dbg_i && !locked_region;
  end

  assign prot_o    = prot_q;
  assign loading_o = load_q;

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> $stable(prot_q));
  assert_dbg_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && dbg_i && (cmd_i == CMD_PROG || cmd_i == CMD_PERASE)) |-> !allow_o);
  assert_mass_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_MERASE) |-> allow_o);
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic        hold_i,
  input  logic [3:0]  cmd_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] data_i,
  input  logic        allow_i,
  output op_req_t     op_o,
  output logic        busy_o,
  output logic        exec_o,
  output logic [3:0]  mode_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_req_t          op_q, op_d;
  logic             start;

  assign start  = go_i && !hold_i && !busy_q;
  assign exec_o = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
      op_d   = '{cmd: cmd_i, addr: addr_i, data: data_i, allow: allow_i};
    end else if (exec_o) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  assign op_o   = op_q;
  assign busy_o = busy_q;
  assign mode_o = busy_q ? MODE_BUSY : (done_q ? MODE_DONE : MODE_IDLE);

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !exec_o) |=> (mode_o == MODE_BUSY));
  assert_done_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> (mode_o == MODE_DONE));
  assert_op_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !exec_o) |=> $stable(op_q));
endmodule

// File: rtl/pfc_array.sv
module pfc_array
  import pfc_pkg::*;
#(
  parameter int          WPP        = 4,
  parameter int          MAIN_PAGES = 8,
  parameter int          OPT_WORDS  = 8,
  parameter logic [31:0] OPT_BASE   = 32'h1FF0_0000,
  parameter int          PROT_OFS   = 16
) (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        rst_n,
  input  logic        exec_i,
  input  op_req_t     op_i,
  input  logic        rd_en_i,
  input  logic [31:0] rd_addr_i,
  input  logic        rd_zero_i,
  output logic [31:0] rd_data_o,
  output logic        prot_bit_o
);
  localparam int MAIN_WORDS = WPP * MAIN_PAGES;
  localparam int TOTAL      = MAIN_WORDS + OPT_WORDS;
  localparam int IDX_W      = $clog2(TOTAL);
  localparam int PROT_IDX   = MAIN_WORDS + PROT_OFS / 4;
  localparam logic [31:0] MAIN_BYTES = 32'(MAIN_WORDS * 4);
  localparam logic [31:0] OPT_END    = OPT_BASE + 32'(OPT_WORDS * 4);

  logic [31:0] mem_q [TOTAL];
  logic [31:0] mem_d [TOTAL];
  logic        mem_en;
  logic [IDX_W:0] op_loc, rd_loc;
  logic [31:0] rd_q, rd_d;
  logic        op_is_opt;

  function automatic logic [IDX_W:0] locate(input logic [31:0] a);
    if (a < MAIN_BYTES) return {1'b1, IDX_W'(a >> 2)};
    if (a >= OPT_BASE && a < OPT_END)
      return {1'b1, IDX_W'((a - OPT_BASE) >> 2) + IDX_W'(MAIN_WORDS)};
    return '0;
  endfunction

  assign op_loc    = locate(op_i.addr);
  assign rd_loc    = locate(rd_addr_i);
  assign op_is_opt = int'(op_loc[IDX_W-1:0]) >= MAIN_WORDS;
  assign mem_en    = exec_i && op_i.allow;

  always_comb begin
    for (int i = 0; i < TOTAL; i++) mem_d[i] = mem_q[i];
    unique case (op_i.cmd)
      CMD_PROG: begin
        if (op_loc[IDX_W])
          mem_d[op_loc[IDX_W-1:0]] = mem_q[op_loc[IDX_W-1:0]] & op_i.data;
      end
      CMD_PERASE: begin
        for (int i = 0; i < TOTAL; i++) begin
          if (op_loc[IDX_W]) begin
            if (op_is_opt ? (i >= MAIN_WORDS)
                          : (i < MAIN_WORDS && i / WPP == int'(op_loc[IDX_W-1:0]) / WPP))
              mem_d[i] = '1;
          end
        end
      end
      CMD_MERASE: begin
        for (int i = 0; i < TOTAL; i++) mem_d[i] = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= '1;
    end else if (mem_en) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_comb begin
    rd_d = '0;
    if (rd_loc[IDX_W] && !rd_zero_i) rd_d = mem_q[rd_loc[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o  = rd_q;
  assign prot_bit_o = mem_q[PROT_IDX][0];

  assert_masked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_zero_i) |=> (rd_data_o == '0));
  assert_denied_keeps_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !op_i.allow) |=> $stable(prot_bit_o));
endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pfc_pkg::*;
#(
  parameter int          WPP        = 4,
  parameter int          MAIN_PAGES = 8,
  parameter int          OPT_WORDS  = 8,
  parameter logic [31:0] OPT_BASE   = 32'h1FF0_0000,
  parameter int          PROT_OFS   = 16,
  parameter int          BUSY_CYC   = 8
) (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dbg_req,
  input  logic        fl_rd,
  input  logic [31:0] fl_addr,
  output logic [31:0] fl_rdata
);
  logic [31:0] tgt, wd;
  logic [3:0]  cmd, mode;
  logic        go, busy, exec, allow, prot, loading, prot_bit;
  op_req_t     op;

  pfc_regs u_regs (
    .clk, .rst_n,
    .wr_i(reg_wr), .sel_i(reg_sel), .wdata_i(reg_wdata),
    .busy_i(busy), .rej_i(exec && !op.allow), .prot_i(prot), .mode_i(mode),
    .rdata_o(reg_rdata), .tgt_o(tgt), .wd_o(wd), .cmd_o(cmd), .go_o(go)
  );

  pfc_guard #(.WPP(WPP), .OPT_WORDS(OPT_WORDS), .OPT_BASE(OPT_BASE)) u_guard (
    .clk, .rst_n,
    .prot_bit_i(prot_bit), .cmd_i(cmd), .addr_i(tgt), .dbg_i(dbg_req),
    .prot_o(prot), .loading_o(loading), .allow_o(allow)
  );

  pfc_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk, .rst_n,
    .go_i(go), .hold_i(loading), .cmd_i(cmd), .addr_i(tgt), .data_i(wd),
    .allow_i(allow), .op_o(op), .busy_o(busy), .exec_o(exec), .mode_o(mode)
  );

  pfc_array #(.WPP(WPP), .MAIN_PAGES(MAIN_PAGES), .OPT_WORDS(OPT_WORDS),
              .OPT_BASE(OPT_BASE), .PROT_OFS(PROT_OFS)) u_array (
    .clk, .pwr_rst_n, .rst_n,
    .exec_i(exec), .op_i(op),
    .rd_en_i(fl_rd), .rd_addr_i(fl_addr), .rd_zero_i(prot && dbg_req),
    .rd_data_o(fl_rdata), .prot_bit_o(prot_bit)
  );
endmodule

// File: tb/pflash_ctrl_bench.sv
`timescale 1ns/1ps
module pflash_ctrl_bench;
  localparam logic [31:0] OBASE = 32'h1FF0_0000;
  localparam logic [31:0] PROT_ADDR = 32'h1FF0_0010;

  logic        clk = 1'b0;
  logic        pwr_rst_n = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_req = 1'b0;
  logic        fl_rd = 1'b0;
  logic [31:0] fl_addr = '0;
  logic [31:0] fl_rdata;

  int total = 0, bad = 0;
  logic [31:0] bm [40];
  logic mprot = 1'b0;

  always #2 clk = ~clk;

  pflash_ctrl u_pflash_ctrl (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bidx(input logic [31:0] a);
    if (a < 32'd128) return int'(a >> 2);
    if (a >= OBASE && a < OBASE + 32'd32) return 32 + int'((a - OBASE) >> 2);
    return -1;
  endfunction

  function automatic bit exp_allow(input logic [3:0] c, input logic [31:0] a, input logic d);
    if (!mprot) return 1'b1;
    if (c != 4'h4 && c != 4'h8) return 1'b1;
    if (d) return 1'b0;
    if (a < 32'd16) return 1'b0;
    if (a >= OBASE && a < OBASE + 32'd32) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_exec(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d);
    int i = bidx(a);
    if (c == 4'h4 && i >= 0) bm[i] = bm[i] & d;
    else if (c == 4'h8 && i >= 0) begin
      for (int j = 0; j < 40; j++)
        if ((i >= 32) ? (j >= 32) : (j < 32 && j / 4 == i / 4)) bm[j] = '1;
    end else if (c == 4'hA) begin
      for (int j = 0; j < 40; j++) bm[j] = '1;
    end
  endtask

  task automatic reg_write(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic fl_check(input logic [31:0] a, input logic d, input string req);
    logic [31:0] e;
    int i = bidx(a);
    e = (i < 0 || (mprot && d)) ? 32'h0 : bm[i];
    @(negedge clk); fl_rd = 1'b1; fl_addr = a; dbg_req = d;
    @(negedge clk); fl_rd = 1'b0; dbg_req = 1'b0;
    chk(fl_rdata === e, req, fl_rdata, e);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mprot = (bm[bidx(PROT_ADDR)][0] == 1'b0);
  endtask

  // full operation with cycle-exact mode, array and error checks
  task automatic run_op(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                        input logic dbg, input bit flip, input string req);
    logic [31:0] v;
    bit ok;
    reg_write(3'd0, a);
    reg_write(3'd1, d);
    reg_write(3'd2, {28'd0, c});
    ok = exp_allow(c, a, dbg);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 32'hA; dbg_req = dbg;
    @(negedge clk); reg_wr = 1'b0; if (flip) dbg_req = ~dbg;
    #1; chk(reg_rdata[3:0] === 4'hA, "R2 first busy cycle", reg_rdata, 32'hA);
    repeat (7) @(negedge clk);
    #1; chk(reg_rdata[3:0] === 4'hA, "R2 eighth busy cycle", reg_rdata, 32'hA);
    @(negedge clk); dbg_req = 1'b0;
    #1; chk(reg_rdata[3:0] === 4'hE, "R2 done", reg_rdata, 32'hE);
    if (ok) model_exec(c, a, d);
    reg_read(3'd4, v);
    chk(v[0] === !ok, {req, " R10 error flag"}, {31'd0, v[0]}, {31'd0, !ok});
    chk(v[1] === mprot, "R1 status protection", {31'd0, v[1]}, {31'd0, mprot});
    if (v[0]) begin
      reg_write(3'd4, 32'h1);
      reg_read(3'd4, v);
      chk(v[0] === 1'b0, "R10 clear by writing 1", {31'd0, v[0]}, 32'h0);
    end
    fl_check(a, 1'b0, {req, " target after op"});
  endtask

  function automatic logic [31:0] rnd_addr(input bit allow_prot_word);
    int r = int'($urandom_range(0, 39));
    if (r >= 32 && r == 36 && !allow_prot_word) r = 35;
    return (r < 32) ? 32'(r * 4) : OBASE + 32'((r - 32) * 4);
  endfunction

  initial begin : watchdog
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) bm[i] = '1;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mprot = 1'b0;

    // R1 reset state
    reg_read(3'd3, v); chk(v === 32'h6, "R1 mode after reset", v, 32'h6);
    reg_read(3'd4, v); chk(v === 32'h0, "R1 status after reset", v, 32'h0);
    fl_check(32'h20, 1'b1, "R4 erased word reads ones");

    // R4 program clears bits only
    run_op(4'h4, 32'h14, 32'h1234_5678, 1'b0, 1'b0, "R4 program");
    run_op(4'h4, 32'h14, 32'hFFFF_0F0F, 1'b1, 1'b0, "R4 program AND");
    fl_check(32'h14, 1'b1, "R7 unprotected debug read");

    // R3 writes during busy ignored
    reg_write(3'd0, 32'h40);
    reg_write(3'd1, 32'h0000_00FF);
    reg_write(3'd2, 32'h4);
    reg_write(3'd3, 32'hA);
    reg_write(3'd0, 32'h44);
    reg_write(3'd2, 32'h8);
    reg_read(3'd0, v); chk(v === 32'h40, "R3 target held while busy", v, 32'h40);
    reg_read(3'd2, v); chk(v === 32'h4, "R3 command held while busy", v, 32'h4);
    repeat (4) @(negedge clk);
    reg_read(3'd3, v); chk(v === 32'hE, "R2 done after poke", v, 32'hE);
    model_exec(4'h4, 32'h40, 32'h0000_00FF);
    fl_check(32'h40, 1'b0, "R3 programmed with held data");
    fl_check(32'h44, 1'b0, "R3 neighbour untouched");

    // R5 page erase of main page 1 and option area
    run_op(4'h4, 32'h18, 32'h0, 1'b0, 1'b0, "R5 setup");
    run_op(4'h8, 32'h1C, 32'h0, 1'b0, 1'b0, "R5 page erase");
    fl_check(32'h14, 1'b0, "R5 page word erased");
    run_op(4'h4, OBASE + 32'h4, 32'h0, 1'b0, 1'b0, "R5 opt setup");
    run_op(4'h8, OBASE + 32'h1C, 32'h0, 1'b0, 1'b0, "R5 opt page erase");
    fl_check(OBASE + 32'h4, 1'b0, "R5 opt area erased");

    // unprotected random mix
    for (int k = 0; k < 30; k++) begin
      logic [3:0] c = ($urandom_range(0, 3) == 0) ? 4'h8 : 4'h4;
      run_op(c, rnd_addr(1'b0), $urandom(), 1'($urandom_range(0, 1)), 1'b0, "R4 random unprotected");
      fl_check(rnd_addr(1'b1), 1'($urandom_range(0, 1)), "R7 random unprotected read");
    end

    // R1 protection programmed but not yet active
    run_op(4'h4, 32'h4, 32'hCAFE_0001, 1'b0, 1'b0, "R9 page0 seed");
    run_op(4'h4, PROT_ADDR, 32'hFFFF_FFFE, 1'b0, 1'b0, "R1 program protection bit");
    fl_check(32'h4, 1'b1, "R1 no effect before reset");
    sys_reset();
    reg_read(3'd4, v); chk(v[1] === 1'b1, "R1 protection after reset", v, 32'h2);
    reg_read(3'd3, v); chk(v === 32'h6, "R1 mode after system reset", v, 32'h6);
    fl_check(32'h4, 1'b1, "R7 protected debug read is zero");
    fl_check(32'h4, 1'b0, "R7 protected user read");

    // R8 / R9 directed
    run_op(4'h4, 32'h30, 32'h0, 1'b1, 1'b0, "R8 debug program rejected");
    run_op(4'h8, 32'h30, 32'h0, 1'b1, 1'b0, "R8 debug erase rejected");
    run_op(4'h8, 32'h0, 32'h0, 1'b0, 1'b0, "R9 page0 erase rejected");
    run_op(4'h4, OBASE, 32'h0, 1'b0, 1'b0, "R9 option program rejected");
    run_op(4'h4, 32'h30, 32'h0F0F_0F0F, 1'b0, 1'b0, "R9 user program accepted");
    // R11 requester taken at commit
    run_op(4'h4, 32'h34, 32'h00FF_00FF, 1'b0, 1'b1, "R11 user commit then debug high");
    run_op(4'h4, 32'h38, 32'h0, 1'b1, 1'b1, "R11 debug commit then debug low");

    // protected random mix
    for (int k = 0; k < 30; k++) begin
      logic [3:0] c = ($urandom_range(0, 2) == 0) ? 4'h8 : 4'h4;
      run_op(c, rnd_addr(1'b1), $urandom(), 1'($urandom_range(0, 1)), 1'b0, "R9 random protected");
      fl_check(rnd_addr(1'b1), 1'($urandom_range(0, 1)), "R7 random protected read");
    end

    // R6 mass erase from debug clears protection after reset
    run_op(4'hA, 32'h0, 32'h0, 1'b1, 1'b0, "R6 debug mass erase");
    fl_check(32'h30, 1'b0, "R6 main erased");
    fl_check(PROT_ADDR, 1'b0, "R6 option erased");
    reg_read(3'd4, v); chk(v[1] === 1'b1, "R1 protection held until reset", v, 32'h2);
    sys_reset();
    reg_read(3'd4, v); chk(v[1] === 1'b0, "R6 protection off after reset", v, 32'h0);
    fl_check(32'h4, 1'b1, "R6 debug read after unlock");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule